// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Interlock Controller

This controller sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it sees the instruction in decode as an operation class plus three register fields. It keeps its own record of the younger stages (execute, memory, writeback), holding for each one the operation class, the destination register and a write flag.

It produces two outputs. The first is a select for the operand-A multiplexer, which picks the result of an ALU-class instruction in execute in place of the register-file read. The second is a stall. The stall covers every remaining read-after-write dependence. The only case dropped from it is a first-operand match against an ALU-class producer in execute, because the bypass covers exactly that case.

When the stall is raised, the decode instruction is held and a bubble enters execute. The memory and writeback records always move forward by one stage. The datapath multiplexer, the ALU and the register file are outside this block.

Top module: `byp_ctrl`

## Requirements
- R1: Class codes on `d_cls` are: 0 bubble, 1 register ALU, 2 immediate ALU, 3 load, 4 store, 5 branch-on-zero, 6 jump, 7 jump-and-link, 8 jump-register, 9 jump-register-and-link. After reset all three younger stages hold bubbles, so a bubble in decode gives `stall`=0 and `opa_sel`=0.
- R2: `opa_sel` is 1 exactly when all three of these hold: the decode instruction reads its first source; execute holds a register or immediate ALU instruction with a nonzero destination; and that destination equals `d_rs`. In that case the match adds no stall. A dependent ALU pair issued back to back therefore runs with zero stall cycles.
- R3: `opa_sel` is 0 when the decode class does not read its first source (bubble, jump, jump-and-link), whatever `d_rs` holds.
- R4: A load in execute whose destination matches the decode first source raises `stall` and never `opa_sel`. A dependent instruction issued right after a load waits 3 cycles.
- R5: A link instruction (class 7 or 9, which writes register 31) in execute raises `stall` for a decode instruction that reads register 31 as its first source. The dependent instruction waits 3 cycles.
- R6: First-source matches against writing instructions in memory or writeback always stall. With one unrelated instruction between producer and consumer the wait is 2 cycles; with two it is 1 cycle.
- R7: The second source is read by register-ALU and store classes only. A match against any writing stage stalls and is never bypassed: 3 cycles when issued right after the producer.
- R8: While `stall` is 1, the decode instruction stays put and a bubble enters execute. Otherwise the decode instruction enters execute, and the memory and writeback records follow execute every cycle.
- R9: The destination is `d_rd` for class 1, `d_rt` for classes 2 and 3, and register 31 for classes 7 and 9. A destination of register 0 never causes a stall or a bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_cls | input | 4 | Operation class of the decode instruction |
| d_rs | input | 5 | First source register field |
| d_rt | input | 5 | Second source, or destination for immediate ALU and load |
| d_rd | input | 5 | Destination field of register ALU |
| opa_sel | output | 1 | 1 selects the execute ALU result as operand A |
| stall | output | 1 | Hold decode and insert a bubble into execute |

## Verification
The assertions rely on a decode class that is one of the ten defined codes. They also rely on the decode fields staying constant through every stalled cycle, since that is how the surrounding pipeline behaves. The bench drives only legal class codes. It changes the decode inputs only when presenting a new instruction, and it keeps the same inputs on the port for as long as `stall` stays high. Scenarios are separated by bubbles that drain the younger stages, so each stall count and select value is set only by the instructions of its own scenario.

// File: rtl/byp_pkg.sv
package byp_pkg;
   localparam int unsigned RW = 5;
   localparam int unsigned CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      OP_NOP  = 4'd0,
      OP_ALU  = 4'd1,
      OP_ALUI = 4'd2,
      OP_LW   = 4'd3,
      OP_SW   = 4'd4,
      OP_BZ   = 4'd5,
      OP_J    = 4'd6,
      OP_JAL  = 4'd7,
      OP_JR   = 4'd8,
      OP_JALR = 4'd9
   } op_cls_e;

   typedef struct packed {
      op_cls_e         cls;
      logic [RW-1:0]   ws;
      logic            we;
   } stage_t;

   localparam stage_t BUBBLE = '{cls: OP_NOP, ws: '0, we: 1'b0};
endpackage

// File: rtl/byp_decode.sv
module byp_decode
   import byp_pkg::*;
#(
   parameter int unsigned LINK_REG = 31
) (
   input  op_cls_e          cls,
   input  logic [RW-1:0]    rs,
   input  logic [RW-1:0]    rt,
   input  logic [RW-1:0]    rd,
   output stage_t           info,
   output logic             re1,
   output logic             re2
);
   localparam logic [RW-1:0] LINK_IDX = RW'(LINK_REG);

   logic unused_rs;
   assign unused_rs = ^rs;

   always_comb begin
      info = BUBBLE;
      info.cls = cls;
      unique case (cls)
         OP_ALU: begin
            info.ws = rd;
            info.we = (rd != '0);
         end
         OP_ALUI, OP_LW: begin
            info.ws = rt;
            info.we = (rt != '0);
         end
         OP_JAL, OP_JALR: begin
            info.ws = LINK_IDX;
            info.we = 1'b1;
         end
         default: begin
            info.ws = '0;
            info.we = 1'b0;
         end
      endcase
   end

   always_comb begin
      re1 = cls inside {OP_ALU, OP_ALUI, OP_LW, OP_SW, OP_BZ, OP_JR, OP_JALR};
      re2 = cls inside {OP_ALU, OP_SW};
   end
endmodule

// File: rtl/byp_pipe.sv
module byp_pipe
   import byp_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   stall,
   input  stage_t d_info,
   output stage_t e_stg,
   output stage_t m_stg,
   output stage_t w_stg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_stg <= BUBBLE;
         m_stg <= BUBBLE;
         w_stg <= BUBBLE;
      end else begin
         e_stg <= stall ? BUBBLE : d_info;
         m_stg <= e_stg;
         w_stg <= m_stg;
      end
   end

   // R8
   bubble_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (e_stg.cls == OP_NOP && !e_stg.we));

   // R8
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> (e_stg == $past(d_info)));

   // R8
   mem_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (m_stg == $past(e_stg) && w_stg == $past(m_stg)));
endmodule

// File: rtl/byp_hazard.sv
module byp_hazard
   import byp_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   d_rs,
   input  logic [RW-1:0]   d_rt,
   input  logic            re1,
   input  logic            re2,
   input  stage_t          e_stg,
   input  stage_t          m_stg,
   input  stage_t          w_stg,
   output logic            opa_sel,
   output logic            stall
);
   localparam int unsigned NLATE = 2;

   stage_t late [NLATE];
   logic [NLATE-1:0] rs_late_hit;
   logic [NLATE-1:0] rt_late_hit;
   logic e_fwd, e_hold, rs_e_hit, rt_e_hit, rs_any, rt_any;

   always_comb begin
      late[0] = m_stg;
      late[1] = w_stg;
   end

   for (genvar i = 0; i < NLATE; i++) begin : g_late
      assign rs_late_hit[i] = late[i].we && (late[i].ws == d_rs);
      assign rt_late_hit[i] = late[i].we && (late[i].ws == d_rt);
   end

   always_comb begin
      e_fwd  = (e_stg.cls inside {OP_ALU, OP_ALUI}) && (e_stg.ws != '0);
      e_hold = ((e_stg.cls == OP_LW) && (e_stg.ws != '0)) ||
               (e_stg.cls inside {OP_JAL, OP_JALR});
   end

   if (BYPASS_EN) begin : g_bypass
      assign opa_sel  = re1 && e_fwd && (d_rs == e_stg.ws);
      assign rs_e_hit = e_hold && (d_rs == e_stg.ws);
   end else begin : g_interlock
      assign opa_sel  = 1'b0;
      assign rs_e_hit = e_stg.we && (d_rs == e_stg.ws);
   end

   assign rt_e_hit = e_stg.we && (d_rt == e_stg.ws);
   assign rs_any   = re1 && (rs_e_hit || (|rs_late_hit));
   assign rt_any   = re2 && (rt_e_hit || (|rt_late_hit));
   assign stall    = rs_any || rt_any;

   // R4
   load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re1 && e_stg.cls == OP_LW && e_stg.ws != '0 && e_stg.ws == d_rs) |-> (stall && !opa_sel));

   // R2
   bypass_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opa_sel |-> (e_stg.cls inside {OP_ALU, OP_ALUI} && e_stg.we));

   // R9
   zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_stg.ws == '0) |-> !opa_sel);

   // R7
   rt_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re2 && e_stg.we && e_stg.ws == d_rt) |-> stall);
endmodule

// File: rtl/byp_ctrl.sv
module byp_ctrl
   import byp_pkg::*;
#(
   parameter int unsigned LINK_REG  = 31,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CLS_W-1:0]    d_cls,
   input  logic [RW-1:0]       d_rs,
   input  logic [RW-1:0]       d_rt,
   input  logic [RW-1:0]       d_rd,
   output logic                opa_sel,
   output logic                stall
);
   if (LINK_REG == 0 || LINK_REG >= (1 << RW)) begin : g_bad_link
      $error("LINK_REG must name a nonzero register");
   end

   op_cls_e cls_in;
   stage_t  d_info, e_stg, m_stg, w_stg;
   logic    re1, re2;

   assign cls_in = op_cls_e'(d_cls);

   byp_decode #(.LINK_REG(LINK_REG)) u_dec (
      .cls  (cls_in),
      .rs   (d_rs),
      .rt   (d_rt),
      .rd   (d_rd),
      .info (d_info),
      .re1  (re1),
      .re2  (re2)
   );

   byp_pipe u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stall),
      .d_info (d_info),
      .e_stg  (e_stg),
      .m_stg  (m_stg),
      .w_stg  (w_stg)
   );

   byp_hazard #(.BYPASS_EN(BYPASS_EN)) u_haz (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_rs    (d_rs),
      .d_rt    (d_rt),
      .re1     (re1),
      .re2     (re2),
      .e_stg   (e_stg),
      .m_stg   (m_stg),
      .w_stg   (w_stg),
      .opa_sel (opa_sel),
      .stall   (stall)
   );

   // R1
   legal_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_cls <= 4'd9);
endmodule

// File: tb/byp_ctrl_test.sv
`timescale 1ns/1ps
module byp_ctrl_test;
   import byp_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] d_cls = 4'd0;
   logic [4:0] d_rs = '0, d_rt = '0, d_rd = '0;
   logic opa_sel, stall;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   byp_ctrl uut (
      .clk(clk), .rst_n(rst_n), .d_cls(d_cls), .d_rs(d_rs),
      .d_rt(d_rt), .d_rd(d_rd), .opa_sel(opa_sel), .stall(stall)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic issue(input op_cls_e c, input int rs, input int rt, input int rd,
                        output int ns, output logic a);
      @(negedge clk);
      d_cls = c; d_rs = 5'(rs); d_rt = 5'(rt); d_rd = 5'(rd);
      #1;
      ns = 0;
      while (stall && ns < 20) begin
         ns++;
         @(negedge clk);
         #1;
      end
      a = opa_sel;
      @(posedge clk);
   endtask

   task automatic expect_issue(input op_cls_e c, input int rs, input int rt, input int rd,
                               input int exp_ns, input logic exp_a, input string tag);
      int ns;
      logic a;
      issue(c, rs, rt, rd, ns, a);
      chk(ns == exp_ns, {tag, " stall cycles"}, ns, exp_ns);
      chk(a == exp_a, {tag, " opa_sel"}, int'(a), int'(exp_a));
   endtask

   task automatic drain();
      for (int i = 0; i < 3; i++) expect_issue(OP_NOP, 0, 0, 0, 0, 1'b0, "drain");
   endtask

   task automatic t_reset();
      #1;
      chk(stall == 1'b0, "R1 reset stall", int'(stall), 0);
      chk(opa_sel == 1'b0, "R1 reset opa_sel", int'(opa_sel), 0);
      @(negedge clk); rst_n = 1'b1;
      expect_issue(OP_ALU, 1, 2, 3, 0, 1'b0, "R1 empty pipe");
      drain();
   endtask

   task automatic t_alu_bypass();
      expect_issue(OP_ALU, 0, 0, 1, 0, 1'b0, "R2 producer");
      expect_issue(OP_ALUI, 1, 4, 0, 0, 1'b1, "R2 back-to-back bypass");
      expect_issue(OP_ALU, 4, 0, 9, 0, 1'b1, "R2 chained bypass");
      drain();
      expect_issue(OP_ALUI, 0, 6, 0, 0, 1'b0, "R9 imm producer");
      expect_issue(OP_SW, 6, 0, 0, 0, 1'b1, "R9 imm dest is rt");
      drain();
   endtask

   task automatic t_no_read();
      expect_issue(OP_ALU, 1, 2, 0, 0, 1'b0, "R9 rd zero producer");
      expect_issue(OP_ALU, 0, 3, 7, 0, 1'b0, "R9 r0 never bypassed");
      expect_issue(OP_J, 7, 0, 0, 0, 1'b0, "R3 jump ignores rs");
      drain();
      expect_issue(OP_ALU, 0, 0, 12, 0, 1'b0, "R3 producer");
      expect_issue(OP_JAL, 12, 12, 12, 0, 1'b0, "R3 link ignores fields");
      drain();
   endtask

   task automatic t_load();
      expect_issue(OP_LW, 0, 1, 0, 0, 1'b0, "R4 load");
      expect_issue(OP_ALU, 1, 0, 2, 3, 1'b0, "R4 load-use stall");
      expect_issue(OP_ALU, 2, 0, 3, 0, 1'b1, "R8 stalled consumer advanced");
      drain();
      expect_issue(OP_LW, 0, 0, 0, 0, 1'b0, "R9 load to r0");
      expect_issue(OP_ALU, 0, 0, 3, 0, 1'b0, "R9 load to r0 no stall");
      drain();
   endtask

   task automatic t_link();
      expect_issue(OP_JAL, 0, 0, 0, 0, 1'b0, "R5 jal");
      expect_issue(OP_JR, 31, 0, 0, 3, 1'b0, "R5 jal then jr r31");
      drain();
      expect_issue(OP_JALR, 4, 0, 0, 0, 1'b0, "R5 jalr");
      expect_issue(OP_ALU, 31, 0, 5, 3, 1'b0, "R5 jalr then use r31");
      drain();
   endtask

   task automatic t_late();
      expect_issue(OP_ALU, 0, 0, 5, 0, 1'b0, "R6 producer");
      expect_issue(OP_NOP, 0, 0, 0, 0, 1'b0, "R6 gap");
      expect_issue(OP_ALU, 5, 0, 6, 2, 1'b0, "R6 memory-stage rs");
      drain();
      expect_issue(OP_ALU, 0, 0, 8, 0, 1'b0, "R6 producer2");
      expect_issue(OP_NOP, 0, 0, 0, 0, 1'b0, "R6 gap a");
      expect_issue(OP_NOP, 0, 0, 0, 0, 1'b0, "R6 gap b");
      expect_issue(OP_BZ, 8, 0, 0, 1, 1'b0, "R6 writeback-stage rs");
      drain();
   endtask

   task automatic t_rt();
      expect_issue(OP_ALU, 0, 0, 1, 0, 1'b0, "R7 producer");
      expect_issue(OP_ALU, 0, 1, 2, 3, 1'b0, "R7 alu rt stall");
      drain();
      expect_issue(OP_ALU, 0, 0, 1, 0, 1'b0, "R7 producer2");
      expect_issue(OP_SW, 2, 1, 0, 3, 1'b0, "R7 store data stall");
      drain();
      expect_issue(OP_ALU, 0, 0, 1, 0, 1'b0, "R7 producer3");
      expect_issue(OP_SW, 1, 0, 0, 0, 1'b1, "R7 store base bypassed");
      drain();
      expect_issue(OP_ALU, 0, 0, 3, 0, 1'b0, "R7 producer4");
      expect_issue(OP_BZ, 0, 3, 0, 0, 1'b0, "R7 branch does not read rt");
      drain();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1 completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_alu_bypass();
      t_no_read();
      t_load();
      t_link();
      t_late();
      t_rt();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule